// File: doc/BRIEF.md
# Multi-Channel Compare General Timer

A 32-bit counting timer with three compare channels, a 12-bit prescaler, a selectable tick source and detection of counter wrap. Software reaches it through a word-addressed register port: writes take effect on the clock edge and reads return combinationally. Eight tick-enable inputs, one per value of a 3-bit source field, feed the counting logic. Code 0 selects nothing, so the counter stays still.

Each compare channel raises a status flag on the clock edge that makes the counter equal to its compare value. Counter wrap raises a separate flag. Software clears flags by writing 1s to them. A single level interrupt combines the flags that are enabled. Two counting styles exist. In free-run, the counter passes every compare value and wraps at all-ones. In restart, a hit on channel 1 sends the counter back to 0 on the next counting step.

A software reset is requested through a control bit. It returns the block to its start state but keeps the enable, mode and source control bits. An asynchronous hard reset clears everything.

Top module: `gtimer_top`

## Requirements
- R1: Word offsets: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7 and 8 capture (always read 0), 9 counter. Any other offset reads 0. Narrower fields read zero-extended.
- R2: Control layout: bit 0 enable, bit 1 enable-mode, bit 3 wait enable, bit 5 stop enable, bits 8:6 source, bit 9 free-run, bit 15 software reset. Bits 2, 4, 10–14 and 15 always read 0.
- R3: The prescaler field is 12 bits wide. With prescaler value P, the counter advances once every P+1 selected ticks, and each step adds 1.
- R4: Source code s selects tick input s. Code 0 selects no tick, and no tick on an unselected input moves the counter.
- R5: Status has 6 flags: bit 0/1/2 compare 1/2/3, bits 3–4 capture (always 0), bit 5 rollover. Writing 1 to a flag clears it, and writing 0 leaves it. A flag set on the same edge as its clear stays set.
- R6: `irqOut` is high exactly when the enable bit is set and some status flag has its interrupt enable bit set. The interrupt enable register uses the same bit order as status.
- R7: A compare flag is set on the edge where the counter becomes equal to that channel's value. In free-run the counter keeps counting past the value.
- R8: In restart mode (free-run bit 0), the next step after the counter equals compare 1 loads 0 and does not set rollover.
- R9: Stepping from all-ones (other than through a compare-1 restart) wraps the counter to 0 and sets the rollover flag.
- R10: In restart mode, a write to compare 1 sets the counter to 0. In free-run mode the write leaves the counter alone.
- R11: A control write that raises enable while enable-mode is set zeroes the counter. Raising enable with enable-mode clear resumes from the held count.
- R12: A control write with bit 15 set clears status, prescaler, interrupt enable and counter, and sets the compare registers to all-ones. Control keeps only bits 0–8 of the written value, with bits 2 and 4 still 0.
- R13: Hard reset (`rstN` low) clears control, status, prescaler, interrupt enable and counter, sets the compare registers to all-ones, and holds `irqOut` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low hard reset |
| busAddr | input | ADDR_W (4) | Register word offset |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | DATA_W (32) | Write data |
| busRdData | output | DATA_W (32) | Combinational read data of the addressed register |
| tickSrc | input | 8 | One tick enable per source code |
| irqOut | output | 1 | Level interrupt |

## Verification
A tick on the same edge as a write-1-to-clear is aimed at the set-over-clear priority; a design that lets the clear win loses an event. The bench walks the counter up to all-ones and one step past, then repeats the compare-1 hit in restart mode. These runs separate a wrap that forgets the rollover flag from a restart that sets it wrongly or lets the counter run on. Compare-1 writes are issued in both modes, and enable is raised with and without enable-mode. A block that ignores the mode zeroes or keeps the count in the wrong case. Software reset is issued with all-ones data so that a wrong keep mask shows up in the control read-back.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
  localparam int SRC_W   = 3;
  localparam int NUM_SRC = 1 << SRC_W;
  localparam int NUM_CMP = 3;
  localparam int FLAG_W  = 6;

  // register word offsets
  localparam int A_CTRL = 0;
  localparam int A_PRE  = 1;
  localparam int A_STAT = 2;
  localparam int A_IEN  = 3;
  localparam int A_CMP0 = 4;
  localparam int A_CNT  = 9;

  // control bit positions
  localparam int B_EN     = 0;
  localparam int B_ENMODE = 1;
  localparam int B_SRC_LO = 6;
  localparam int B_FREE   = 9;
  localparam int B_SWR    = 15;

  // status bit positions
  localparam int F_ROLL = 5;

  localparam logic [31:0] STORE_MASK = 32'h0000_03EB;
  localparam logic [31:0] KEEP_MASK  = 32'h0000_01EB;

  // strobes from control to datapath
  typedef struct packed {
    logic enabled;
    logic tickEn;
    logic restartMode;
    logic zeroCount;
  } gtStrobe_t;

  // events from datapath to control
  typedef struct packed {
    logic [NUM_CMP-1:0] cmpHit;
    logic               wrapHit;
  } gtEvent_t;
endpackage

// File: rtl/gtimer_datapath.sv
module gtimer_datapath
  import gtimer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  gtStrobe_t                     strobe,
  input  logic [PRE_W-1:0]              prescale,
  input  logic [NUM_CMP-1:0][CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0]              countVal,
  output logic                          advance,
  output gtEvent_t                      evt
);
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] nextCount;
  logic             restartHit;

  assign advance    = strobe.tickEn && (preCnt >= prescale);
  assign restartHit = strobe.restartMode && (countVal == cmpVal[0]);
  assign nextCount  = restartHit ? '0 : countVal + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      countVal <= '0;
    end else if (strobe.zeroCount) begin
      preCnt   <= '0;
      countVal <= '0;
    end else if (strobe.tickEn) begin
      if (advance) begin
        preCnt   <= '0;
        countVal <= nextCount;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_hit
    assign evt.cmpHit[i] = advance && !strobe.zeroCount && (nextCount == cmpVal[i]);
  end
  assign evt.wrapHit = advance && !strobe.zeroCount && !restartHit && (&countVal);
endmodule

// File: rtl/gtimer_ctrl.sv
module gtimer_ctrl
  import gtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWrEn,
  input  logic [DATA_W-1:0]             busWrData,
  output logic [DATA_W-1:0]             busRdData,
  input  logic [NUM_SRC-1:0]            tickSrc,
  input  logic [CNT_W-1:0]              countVal,
  input  gtEvent_t                      evt,
  output gtStrobe_t                     strobe,
  output logic [PRE_W-1:0]              prescale,
  output logic [NUM_CMP-1:0][CNT_W-1:0] cmpVal,
  output logic [FLAG_W-1:0]             statusVal,
  output logic                          irqOut
);
  logic [DATA_W-1:0] ctrlReg;
  logic [FLAG_W-1:0] ienReg;
  logic [SRC_W-1:0]  srcSel;
  logic wrCtrl, softRst, enRise, cmp0Restart, wrStat;
  logic [FLAG_W-1:0] setFlags, clrFlags;

  assign wrCtrl      = busWrEn && (busAddr == ADDR_W'(A_CTRL));
  assign wrStat      = busWrEn && (busAddr == ADDR_W'(A_STAT));
  assign softRst     = wrCtrl && busWrData[B_SWR];
  assign enRise      = wrCtrl && !softRst && busWrData[B_EN] && !ctrlReg[B_EN]
                       && busWrData[B_ENMODE];
  assign cmp0Restart = busWrEn && (busAddr == ADDR_W'(A_CMP0)) && !ctrlReg[B_FREE];
  assign srcSel      = ctrlReg[B_SRC_LO +: SRC_W];

  assign strobe.enabled     = ctrlReg[B_EN];
  assign strobe.tickEn      = ctrlReg[B_EN] && (srcSel != '0) && tickSrc[srcSel];
  assign strobe.restartMode = !ctrlReg[B_FREE];
  assign strobe.zeroCount   = softRst || enRise || cmp0Restart;

  assign setFlags = {evt.wrapHit, 2'b00, evt.cmpHit};
  assign clrFlags = wrStat ? busWrData[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      prescale  <= '0;
      ienReg    <= '0;
      statusVal <= '0;
      cmpVal    <= '1;
    end else if (softRst) begin
      ctrlReg   <= busWrData & DATA_W'(KEEP_MASK);
      prescale  <= '0;
      ienReg    <= '0;
      statusVal <= '0;
      cmpVal    <= '1;
    end else begin
      if (wrCtrl) ctrlReg <= busWrData & DATA_W'(STORE_MASK);
      if (busWrEn && busAddr == ADDR_W'(A_PRE)) prescale <= busWrData[PRE_W-1:0];
      if (busWrEn && busAddr == ADDR_W'(A_IEN)) ienReg <= busWrData[FLAG_W-1:0];
      for (int i = 0; i < NUM_CMP; i++) begin
        if (busWrEn && busAddr == ADDR_W'(A_CMP0 + i)) cmpVal[i] <= busWrData[CNT_W-1:0];
      end
      statusVal <= (statusVal & ~clrFlags) | setFlags;
    end
  end

  assign irqOut = ctrlReg[B_EN] && |(statusVal & ienReg);

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(A_CTRL):     busRdData = ctrlReg;
      ADDR_W'(A_PRE):      busRdData = DATA_W'(prescale);
      ADDR_W'(A_STAT):     busRdData = DATA_W'(statusVal);
      ADDR_W'(A_IEN):      busRdData = DATA_W'(ienReg);
      ADDR_W'(A_CMP0):     busRdData = DATA_W'(cmpVal[0]);
      ADDR_W'(A_CMP0 + 1): busRdData = DATA_W'(cmpVal[1]);
      ADDR_W'(A_CMP0 + 2): busRdData = DATA_W'(cmpVal[2]);
      ADDR_W'(A_CNT):      busRdData = DATA_W'(countVal);
      default:             busRdData = '0;
    endcase
  end
endmodule

// File: rtl/gtimer_top.sv
module gtimer_top
  import gtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [7:0]        tickSrc,
  output logic              irqOut
);
  gtStrobe_t                     strobe;
  gtEvent_t                      evt;
  logic [PRE_W-1:0]              prescale;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmpVal;
  logic [CNT_W-1:0]              countVal;
  logic [FLAG_W-1:0]             statusVal;
  logic                          advance;

  gtimer_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tickSrc(tickSrc),
    .countVal(countVal), .evt(evt), .strobe(strobe), .prescale(prescale),
    .cmpVal(cmpVal), .statusVal(statusVal), .irqOut(irqOut)
  );

  gtimer_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prescale(prescale),
    .cmpVal(cmpVal), .countVal(countVal), .advance(advance), .evt(evt)
  );
endmodule

// File: rtl/gtimer_checks.sv
module gtimer_checks
  import gtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input gtStrobe_t         strobe,
  input logic              advance,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  cmp0,
  input logic [FLAG_W-1:0] statusVal,
  input logic              irqOut
);
  logic statTouch;
  assign statTouch = busWrEn && ((busAddr == ADDR_W'(A_STAT)) ||
                     ((busAddr == ADDR_W'(A_CTRL)) && busWrData[B_SWR]));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tickEn && !strobe.zeroCount) |=> $stable(countVal));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !strobe.zeroCount && !strobe.restartMode)
      |=> (countVal == CNT_W'($past(countVal) + 1'b1)));

  p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !strobe.zeroCount && strobe.restartMode && countVal == cmp0)
      |=> (countVal == '0));

  p_flags_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !statTouch |=> ((statusVal & $past(statusVal)) == $past(statusVal)));

  p_capture_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
    statusVal[4:3] == 2'b00);

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enabled |-> !irqOut);

  p_zero_request_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroCount |=> (countVal == '0));
endmodule

bind gtimer_top gtimer_checks #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .strobe(strobe), .advance(advance),
  .countVal(countVal), .cmp0(cmpVal[0]), .statusVal(statusVal), .irqOut(irqOut)
);

// File: tb/tb_gtimer_top.sv
module tb_gtimer_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  tickSrc = '0;
  logic        irqOut;
  int total = 0;
  int bad = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  gtimer_top #(.CNT_W(8)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tickSrc(tickSrc), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickSrc[src] = 1'b1;
      @(negedge clk); tickSrc[src] = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd(0, v); check("R13 ctrl", v, 0);
    rd(2, v); check("R13 status", v, 0);
    rd(4, v); check("R13 cmp1", v, 32'hFF);
    rd(9, v); check("R13 count", v, 0);
    check("R13 irq", irqOut, 0);
  endtask

  task automatic t_map;
    wr(0, 32'hFFFF_7FFF); rd(0, v); check("R2 ctrl mask", v, 32'h3EB);
    wr(0, 0);
    wr(1, 32'hFFFFF); rd(1, v); check("R3 prescaler width", v, 32'hFFF);
    wr(3, 32'hFF); rd(3, v); check("R1 ien width", v, 32'h3F);
    wr(5, 32'h33); rd(5, v); check("R1 cmp2 readback", v, 32'h33);
    rd(7, v); check("R1 capture1", v, 0);
    rd(8, v); check("R1 capture2", v, 0);
    rd(12, v); check("R1 unmapped", v, 0);
    wr(1, 0); wr(3, 0);
  endtask

  task automatic t_source;
    wr(0, 32'h201);
    for (int s = 0; s < 8; s++) pulse(s, 1);
    rd(9, v); check("R4 source zero", v, 0);
    wr(0, 32'h281);
    pulse(1, 5); rd(9, v); check("R4 unselected input", v, 0);
    pulse(2, 5); rd(9, v); check("R4 selected input", v, 5);
  endtask

  task automatic t_prescale;
    wr(1, 2);
    pulse(2, 2); rd(9, v); check("R3 before third tick", v, 5);
    pulse(2, 1); rd(9, v); check("R3 third tick", v, 6);
    pulse(2, 4); rd(9, v); check("R3 seventh tick", v, 7);
    wr(1, 0);
  endtask

  task automatic t_flags;
    wr(0, 32'h8041);
    rd(0, v); check("R12 keep subset", v, 32'h41);
    wr(0, 32'h241);
    wr(4, 3); wr(5, 5); wr(6, 5);
    pulse(1, 2); rd(2, v); check("R7 no flag yet", v, 0);
    pulse(1, 1); rd(9, v); check("R7 count at cmp1", v, 3);
    rd(2, v); check("R7 cmp1 flag", v, 1);
    pulse(1, 2); rd(2, v); check("R7 cmp2 and cmp3 flags", v, 7);
    pulse(1, 1); rd(9, v); check("R7 free-run passes", v, 6);
    check("R6 irq masked", irqOut, 0);
    wr(3, 2); check("R6 irq enabled", irqOut, 1);
    wr(2, 2); rd(2, v); check("R5 w1c", v, 5);
    check("R6 irq after clear", irqOut, 0);
    wr(2, 0); rd(2, v); check("R5 write zero", v, 5);
    wr(2, 1); rd(2, v); check("R5 w1c bit0", v, 4);
    wr(4, 7); rd(9, v); check("R10 free-run cmp1 write", v, 6);
    @(negedge clk);
    tickSrc[1] = 1'b1; busAddr = 2; busWrEn = 1'b1; busWrData = 1;
    @(negedge clk);
    tickSrc[1] = 1'b0; busWrEn = 1'b0;
    rd(2, v); check("R5 set beats clear", v, 5);
    wr(3, 1); check("R6 irq bit0", irqOut, 1);
    wr(0, 32'h240); check("R6 irq disabled", irqOut, 0);
    wr(0, 32'h241); rd(9, v); check("R11 resume without enable-mode", v, 7);
  endtask

  task automatic t_rollover;
    wr(2, 32'h3F);
    pulse(1, 248); rd(9, v); check("R9 all-ones", v, 32'hFF);
    rd(2, v); check("R9 no early flag", v, 0);
    pulse(1, 1); rd(9, v); check("R9 wrap", v, 0);
    rd(2, v); check("R9 rollover flag", v, 32'h20);
  endtask

  task automatic t_restart;
    wr(2, 32'h3F);
    wr(0, 32'h041);
    pulse(1, 2); rd(9, v); check("R8 pre count", v, 2);
    wr(4, 4); rd(9, v); check("R10 restart cmp1 write", v, 0);
    pulse(1, 4); rd(9, v); check("R8 reach cmp1", v, 4);
    rd(2, v); check("R8 cmp1 flag", v, 1);
    pulse(1, 1); rd(9, v); check("R8 back to zero", v, 0);
    rd(2, v); check("R8 no rollover", v, 1);
    pulse(1, 5); rd(9, v); check("R8 second cycle", v, 0);
  endtask

  task automatic t_enmode;
    wr(0, 32'h241);
    pulse(1, 2);
    wr(0, 32'h242);
    wr(0, 32'h243); rd(9, v); check("R11 enable-mode zero", v, 0);
    pulse(1, 3); rd(9, v); check("R11 count after", v, 3);
  endtask

  task automatic t_soft;
    wr(1, 3); wr(3, 32'h3F); wr(5, 32'h12);
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); check("R12 ctrl kept", v, 32'h1EB);
    rd(1, v); check("R12 prescaler", v, 0);
    rd(2, v); check("R12 status", v, 0);
    rd(3, v); check("R12 ien", v, 0);
    rd(9, v); check("R12 count", v, 0);
    rd(5, v); check("R12 cmp2", v, 32'hFF);
  endtask

  task automatic t_hard;
    wr(5, 32'h12);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(0, v); check("R13 ctrl after hard", v, 0);
    rd(5, v); check("R13 cmp2 after hard", v, 32'hFF);
    check("R13 irq after hard", irqOut, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_map();
    t_source();
    t_prescale();
    t_flags();
    t_rollover();
    t_restart();
    t_enmode();
    t_soft();
    t_hard();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule